// File: doc/BRIEF.md
# Bit-Addressable Interrupt Controller

This block gathers up to fifteen interrupt sources into a single interrupt line for a processor. It has one 32-bit register that holds four kinds of field: a master enable, one enable bit for each source, one latched active flag for each source, and a summary bit. The summary bit is set when any source that is enabled is active. Each source input is sampled on every clock. A high level sets the source's active flag, and the flag stays set until software acknowledges it.

A write is decoded bit by bit. Software can therefore enable, disable or acknowledge one source in a single write, without reading the register first. Bit 31 of each write does two jobs. It becomes the new master enable, and it decides whether the enable bits selected in the same write are turned on or off. As a result, any write that disables a source also turns off the master enable. A read strobe copies the current register into the read data output.

Top module: `irqc_hub`

## Requirements
- R1: After reset, every bit of the register is 0, `irq_out` is 0 and `rd_data` is 0.
- R2: The active flag of source i is bit i. It is set at the clock edge after the clock where `irq_src[i]` is high. It then stays set while the input is low and no acknowledge arrives.
- R3: A write with bit i set clears the active flag of source i. A write with bit i clear leaves that flag unchanged.
- R4: If `irq_src[i]` is high in the same cycle as a write that acknowledges source i, the flag is set after the edge.
- R5: The enable bit of source i is bit 16+i. A write with bit 31 set and bit 16+i set turns that enable on. Enables whose bit is 0 in the write do not change.
- R6: A write with bit 31 clear and bit 16+i set turns the enable of source i off. Other enables do not change.
- R7: The master enable is bit 31. Every write loads it from bit 31 of the write data.
- R8: Bit 15 reads as 1 exactly when some source is both active and enabled.
- R9: `irq_out` equals the master enable ANDed with the summary bit, as both stood one clock earlier. It therefore lags the register state by one cycle.
- R10: A read returns the master enable in bit 31, the enables in bits 16 and up, the summary bit in bit 15 and the active flags in bits 0 and up. Bits for sources at or above `NUM_SRC` always read 0, and writes to them have no effect.
- R11: `rd_data` is loaded at the edge that ends a cycle with `rd_stb` high, with the register value from before that edge. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_SRC | Synchronous interrupt source lines |
| wr_stb | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data, decoded bit by bit |
| rd_stb | input | 1 | Register read strobe |
| rd_data | output | 32 | Register value captured by the last read |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the block with `NUM_SRC` = 4, which makes the full cross product small enough to sweep. For every combination of the four active flags, the four enables and the master enable, it checks the read-back word and the interrupt line against values computed arithmetically. With four sources, bits 4 to 14 and 20 to 30 are unused, so a write of all ones shows that those bits stay 0. Directed sequences cover the one-cycle output lag, a set and an acknowledge landing in the same cycle, and a disable write clearing the master enable.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int REG_W      = 32;
    localparam int MAX_SRC    = 15;
    localparam int MASTER_POS = 31;
    localparam int EN_BASE    = 16;
    localparam int ANY_POS    = 15;
    localparam int ACT_BASE   = 0;

    typedef struct packed {
        logic act;
        logic en;
    } slice_t;
endpackage

// File: rtl/irqc_src_slice.sv
module irqc_src_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic set_en_i,
    input  logic clr_en_i,
    input  logic ack_i,
    output logic act_o,
    output logic en_o
);
    import irqc_pkg::*;

    slice_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ack_i)    s_d.act = 1'b0;
        if (src_i)    s_d.act = 1'b1;
        if (set_en_i)      s_d.en = 1'b1;
        else if (clr_en_i) s_d.en = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act_o = s_q.act;
    assign en_o  = s_q.en;

    a_r4_src_wins: assert property (@(posedge clk) disable iff (!rst_n)
        src_i |=> act_o);
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !src_i) |=> !act_o);
    a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o && !ack_i) |=> act_o);
    a_r5_enable_on: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> en_o);
    a_r6_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && !set_en_i) |=> !en_o);
    a_r5_enable_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en_i && !clr_en_i) |=> $stable(en_o));
endmodule

// File: rtl/irqc_any_reduce.sv
module irqc_any_reduce #(
    parameter int N = 15
) (
    input  logic [N-1:0] act_i,
    input  logic [N-1:0] en_i,
    output logic         any_o
);
    logic [N:0] chain;

    assign chain[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_or
        assign chain[g+1] = chain[g] | (act_i[g] & en_i[g]);
    end
    assign any_o = chain[N];
endmodule

// File: rtl/irqc_hub.sv
module irqc_hub #(
    parameter int NUM_SRC = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               wr_stb,
    input  logic [31:0]        wr_data,
    input  logic               rd_stb,
    output logic [31:0]        rd_data,
    output logic               irq_out
);
    import irqc_pkg::*;

    localparam int N = (NUM_SRC > MAX_SRC) ? MAX_SRC : NUM_SRC;

    typedef struct packed {
        logic             master;
        logic             irq;
        logic [REG_W-1:0] rd;
    } hub_t;

    hub_t h_d, h_q;

    logic [N-1:0] set_en, clr_en, ack, act, en;
    logic         any;
    logic [REG_W-1:0] view;

    for (genvar g = 0; g < N; g++) begin : g_src
        assign set_en[g] = wr_stb &  wr_data[MASTER_POS] & wr_data[EN_BASE + g];
        assign clr_en[g] = wr_stb & ~wr_data[MASTER_POS] & wr_data[EN_BASE + g];
        assign ack[g]    = wr_stb & wr_data[ACT_BASE + g];

        irqc_src_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_i    (irq_src[g]),
            .set_en_i (set_en[g]),
            .clr_en_i (clr_en[g]),
            .ack_i    (ack[g]),
            .act_o    (act[g]),
            .en_o     (en[g])
        );
    end

    irqc_any_reduce #(.N(N)) u_any (
        .act_i (act),
        .en_i  (en),
        .any_o (any)
    );

    always_comb begin
        view = '0;
        view[MASTER_POS]     = h_q.master;
        view[EN_BASE +: N]   = en;
        view[ANY_POS]        = any;
        view[ACT_BASE +: N]  = act;
    end

    always_comb begin
        h_d     = h_q;
        h_d.irq = h_q.master & any;
        if (wr_stb) h_d.master = wr_data[MASTER_POS];
        if (rd_stb) h_d.rd     = view;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign rd_data = h_q.rd;
    assign irq_out = h_q.irq;

    a_r7_master_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (h_q.master == $past(wr_data[MASTER_POS])));
    a_r9_out_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(h_q.master));
    a_r9_out_needs_any: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(|(act & en)));
    a_r11_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
    a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_data[EN_BASE +: MAX_SRC]) <= N);
endmodule

// File: tb/irqc_hub_bench.sv
module irqc_hub_bench;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_src = '0;
    logic          wr_stb = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          rd_stb = 1'b0;
    logic [31:0]   rd_data;
    logic          irq_out;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irqc_hub #(.NUM_SRC(NS)) u_irqc_hub (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [31:0] wd, input logic rd,
                       input logic [NS-1:0] src);
        wr_stb = we; wr_data = wd; rd_stb = rd; irq_src = src;
        @(posedge clk); #1;
        wr_stb = 0; wr_data = '0; rd_stb = 0; irq_src = '0;
    endtask

    task automatic idle();  cyc(0, 32'h0, 0, '0); endtask
    task automatic wr(input logic [31:0] d); cyc(1, d, 0, '0); endtask
    task automatic rd();    cyc(0, 32'h0, 1, '0); endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        // R1: reset state
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 irq_out", {31'h0, irq_out}, 32'h0);
        rst_n = 1'b1;
        rd();
        check("R1 register", rd_data, 32'h0);

        // R10: all-ones write; unused bits stay zero, actives cleared
        wr(32'hFFFF_FFFF); idle(); rd();
        check("R10 unused bits", rd_data, 32'h800F_0000);

        // R9: one-cycle lag from active flag to irq_out
        cyc(0, 32'h0, 0, 4'b0100);
        check("R9 lag cycle", {31'h0, irq_out}, 32'h0);
        idle();
        check("R9 asserted", {31'h0, irq_out}, 32'h1);
        rd();
        check("R2 R8 flag and summary", rd_data, 32'h800F_8004);

        // R3: acknowledging with zero elsewhere keeps other flags
        cyc(0, 32'h0, 0, 4'b1001);
        wr(32'h8000_0004); idle(); rd();
        check("R3 ack one", rd_data, 32'h800F_8009);

        // R4: set wins over same-cycle acknowledge
        cyc(1, 32'h8000_0001, 0, 4'b0001); rd();
        check("R4 set wins", rd_data, 32'h800F_8009);

        // R6 / R7: disabling one source leaves others, clears master
        wr(32'h0002_0000); idle(); rd();
        check("R6 disable one", rd_data, 32'h000D_8009);
        check("R7 master cleared", {31'h0, irq_out}, 32'h0);
        wr(32'h8000_0000); idle(); rd();
        check("R7 master on", rd_data, 32'h800D_8009);
        check("R9 irq with master", {31'h0, irq_out}, 32'h1);

        // R11: read data holds without a read strobe
        wr(32'h0000_000F); idle(); idle();
        check("R11 holds", rd_data, 32'h800D_8009);

        // Exhaustive sweep: R5, R8, R9, R10
        for (int e = 0; e < 16; e++) begin
            for (int a = 0; a < 16; a++) begin
                for (int m = 0; m < 2; m++) begin
                    logic anyx;
                    logic [31:0] expv;
                    wr(32'h000F_000F);
                    cyc(0, 32'h0, 0, a[NS-1:0]);
                    wr(32'h8000_0000 | (32'(e) << 16));
                    if (m == 0) wr(32'h0);
                    idle(); rd();
                    anyx = |(a[3:0] & e[3:0]);
                    expv = (32'(m) << 31) | (32'(e) << 16) | (32'(anyx) << 15) | 32'(a);
                    check("R5 R8 R10 sweep read", rd_data, expv);
                    check("R9 sweep irq_out", {31'h0, irq_out}, {31'h0, anyx & (m == 1)});
                end
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule